// File: doc/BRIEF.md
# Post-Reset Program Bootstrap Loader

After a hardware reset this block fills the bottom of a 24-bit program RAM with a user program. The program arrives as bytes over one of two ready/valid byte streams. One stream is a parallel host port. The other is a serial host port, which can use SPI-like or I2C-like framing. A three-bit mode code, sampled once after reset, picks the source and the framing. The block packs every three accepted bytes into one program word, least significant byte first. It writes the words to consecutive RAM addresses starting at 0.

While the load runs, the core is held. Any read the core requests below the end of the loaded region is refused, and reads above that region pass through. After the last word is written, the block raises a one-cycle done pulse and releases the core, which then fetches from address 0. An unsupported mode code releases the core at once and makes no writes.

Top module: `boot_loader_top`

## Requirements
- R1: The mode code is sampled on the first clock edge after reset is released. Code 3'b001 selects the parallel port. Code 3'b010 selects the serial port with SPI framing (`ser_fmt_i2c`=0). Code 3'b011 selects the serial port with I2C framing (`ser_fmt_i2c`=1). Only the selected port's ready can ever be high.
- R2: Each program word is built from three accepted bytes, least significant byte first: word = {byte2, byte1, byte0}.
- R3: Exactly LOAD_WORDS writes are issued, one `ram_we` cycle per word, at addresses 0, 1, … LOAD_WORDS-1 in order.
- R4: The selected port's ready is low in every cycle in which `ram_we` is high. Every byte transferred while ready was high appears in a written word, so no byte is lost when the source stalls.
- R5: While `core_run` is low, a read request with `rd_addr` < LOAD_WORDS is blocked (`ram_rd_en`=0, `rd_blocked`=1). Reads at or above LOAD_WORDS pass (`ram_rd_en`=`rd_en`). Once `core_run` is high, every read passes.
- R6: `boot_done` is high for exactly one cycle, in the cycle after the final write. `core_run` rises in that same cycle and stays high until the next reset.
- R7: Any mode code other than 3'b001, 3'b010 or 3'b011 raises `core_run` one cycle after reset release, with no RAM write and no `boot_done` pulse.
- R8: After `core_run` is high, bytes offered on either port are ignored: both readies stay low and no write occurs.
- R9: While reset is held, `ram_we`, `boot_done`, `core_run` and both readies are low.
- R10: A new reset in the middle of a load restarts the load from address 0 with the newly sampled mode code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| mode_bits | input | 3 | Boot source and framing code |
| par_valid | input | 1 | Parallel host byte valid |
| par_data | input | 8 | Parallel host byte |
| par_ready | output | 1 | Parallel host byte accepted |
| ser_valid | input | 1 | Serial host byte valid |
| ser_data | input | 8 | Serial host byte |
| ser_ready | output | 1 | Serial host byte accepted |
| ser_fmt_i2c | output | 1 | Serial framing: 0 SPI-like, 1 I2C-like |
| ram_we | output | 1 | Program RAM write strobe |
| ram_waddr | output | ADDR_W | Program RAM write address |
| ram_wdata | output | WORD_W | Program RAM write word |
| rd_en | input | 1 | Core read request |
| rd_addr | input | ADDR_W | Core read address |
| ram_rd_en | output | 1 | Read enable passed to the RAM |
| rd_blocked | output | 1 | Read refused because the region is loading |
| boot_done | output | 1 | One-cycle pulse at load completion |
| core_run | output | 1 | Core released to execute from address 0 |

## Verification
The bench uses the default parameters: 24-bit words, 8-bit bytes, a 16-bit address and a full 256-word region. Every load therefore crosses the exact boundary where the last address is written and the done pulse follows. Read probes are spread across 0–511, so they fall on both sides of the protected limit, before and after release. Random valid gaps and junk traffic on the unselected port exercise backpressure across all three source codes. Two unsupported codes, a post-release idle stretch and a reset in the middle of a load are also covered.

// File: rtl/boot_pkg.sv
package boot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } boot_st_e;

    typedef struct packed {
        logic load;
        logic serial;
        logic i2c;
    } src_cfg_t;

    function automatic src_cfg_t decode_mode(input logic [2:0] m);
        src_cfg_t c;
        c = '0;
        case (m)
            3'b001: c = '{load: 1'b1, serial: 1'b0, i2c: 1'b0};
            3'b010: c = '{load: 1'b1, serial: 1'b1, i2c: 1'b0};
            3'b011: c = '{load: 1'b1, serial: 1'b1, i2c: 1'b1};
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/boot_src_mux.sv
module boot_src_mux
    import boot_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  src_cfg_t          cfg,
    input  logic              accept_ok,
    input  logic              par_valid,
    input  logic [BYTE_W-1:0] par_data,
    output logic              par_ready,
    input  logic              ser_valid,
    input  logic [BYTE_W-1:0] ser_data,
    output logic              ser_ready,
    output logic              ser_fmt_i2c,
    output logic              fire,
    output logic [BYTE_W-1:0] byte_data
);

    always_comb begin
        par_ready   = cfg.load && !cfg.serial && accept_ok;
        ser_ready   = cfg.load &&  cfg.serial && accept_ok;
        fire        = (par_valid && par_ready) || (ser_valid && ser_ready);
        byte_data   = cfg.serial ? ser_data : par_data;
        ser_fmt_i2c = cfg.serial && cfg.i2c;
    end

endmodule

// File: rtl/boot_word_pack.sv
module boot_word_pack #(
    parameter int BYTE_W = 8,
    parameter int BYTES  = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    fire,
    input  logic [BYTE_W-1:0]       din,
    output logic                    word_done,
    output logic [BYTES*BYTE_W-1:0] word
);

    localparam int CNT_W = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTES - 1);

    logic [CNT_W-1:0]        slot;
    logic [BYTES*BYTE_W-1:0] acc;
    logic [BYTES*BYTE_W-1:0] merged;

    generate
        for (genvar g = 0; g < BYTES; g++) begin : g_lane
            assign merged[g*BYTE_W +: BYTE_W] =
                (slot == CNT_W'(g)) ? din : acc[g*BYTE_W +: BYTE_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            slot <= '0;
            acc  <= '0;
        end else if (fire) begin
            acc  <= merged;
            slot <= (slot == LAST) ? '0 : slot + 1'b1;
        end
    end

    assign word_done = fire && (slot == LAST);
    assign word      = merged;

endmodule

// File: rtl/boot_seq.sv
module boot_seq
    import boot_pkg::*;
#(
    parameter int WORD_W     = 24,
    parameter int ADDR_W     = 16,
    parameter int LOAD_WORDS = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode_bits,
    input  logic              word_done,
    input  logic [WORD_W-1:0] word,
    output src_cfg_t          cfg,
    output logic              accept_ok,
    output logic              loading,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_waddr,
    output logic [WORD_W-1:0] ram_wdata,
    output logic              boot_done,
    output logic              core_run
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(LOAD_WORDS - 1);

    boot_st_e          st;
    src_cfg_t          cfg_q;
    src_cfg_t          cfg_d;
    logic              pend;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] wdata;
    logic              done_q;

    assign cfg_d = decode_mode(mode_bits);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cfg_q  <= '0;
            pend   <= 1'b0;
            addr   <= '0;
            wdata  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    cfg_q <= cfg_d;
                    st    <= cfg_d.load ? ST_LOAD : ST_RUN;
                end
                ST_LOAD: begin
                    if (pend) begin
                        pend <= 1'b0;
                        addr <= addr + 1'b1;
                        if (addr == LAST_ADDR) begin
                            st     <= ST_RUN;
                            done_q <= 1'b1;
                        end
                    end else if (word_done) begin
                        pend  <= 1'b1;
                        wdata <= word;
                    end
                end
                default: ;
            endcase
        end
    end

    assign cfg       = cfg_q;
    assign loading   = (st == ST_LOAD);
    assign accept_ok = (st == ST_LOAD) && !pend;
    assign ram_we    = pend;
    assign ram_waddr = addr;
    assign ram_wdata = wdata;
    assign boot_done = done_q;
    assign core_run  = (st == ST_RUN);

endmodule

// File: rtl/boot_read_guard.sv
module boot_read_guard #(
    parameter int ADDR_W     = 16,
    parameter int LOAD_WORDS = 256
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              core_run,
    output logic              ram_rd_en,
    output logic              rd_blocked
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(LOAD_WORDS);

    logic in_region;

    always_comb begin
        in_region  = ({1'b0, rd_addr} < LIMIT);
        rd_blocked = rd_en && in_region && !core_run;
        ram_rd_en  = rd_en && !rd_blocked;
    end

endmodule

// File: rtl/boot_loader_top.sv
module boot_loader_top
    import boot_pkg::*;
#(
    parameter int WORD_W     = 24,
    parameter int BYTE_W     = 8,
    parameter int ADDR_W     = 16,
    parameter int LOAD_WORDS = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode_bits,
    input  logic              par_valid,
    input  logic [BYTE_W-1:0] par_data,
    output logic              par_ready,
    input  logic              ser_valid,
    input  logic [BYTE_W-1:0] ser_data,
    output logic              ser_ready,
    output logic              ser_fmt_i2c,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_waddr,
    output logic [WORD_W-1:0] ram_wdata,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              ram_rd_en,
    output logic              rd_blocked,
    output logic              boot_done,
    output logic              core_run
);

    localparam int BYTES_PER_WORD = WORD_W / BYTE_W;

    src_cfg_t          cfg;
    logic              accept_ok;
    logic              loading;
    logic              fire;
    logic [BYTE_W-1:0] byte_data;
    logic              word_done;
    logic [WORD_W-1:0] word;

    boot_src_mux #(.BYTE_W(BYTE_W)) u_mux (
        .cfg         (cfg),
        .accept_ok   (accept_ok),
        .par_valid   (par_valid),
        .par_data    (par_data),
        .par_ready   (par_ready),
        .ser_valid   (ser_valid),
        .ser_data    (ser_data),
        .ser_ready   (ser_ready),
        .ser_fmt_i2c (ser_fmt_i2c),
        .fire        (fire),
        .byte_data   (byte_data)
    );

    boot_word_pack #(.BYTE_W(BYTE_W), .BYTES(BYTES_PER_WORD)) u_pack (
        .clk       (clk),
        .rst       (rst),
        .clear     (!loading),
        .fire      (fire),
        .din       (byte_data),
        .word_done (word_done),
        .word      (word)
    );

    boot_seq #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .LOAD_WORDS(LOAD_WORDS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .mode_bits (mode_bits),
        .word_done (word_done),
        .word      (word),
        .cfg       (cfg),
        .accept_ok (accept_ok),
        .loading   (loading),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_wdata (ram_wdata),
        .boot_done (boot_done),
        .core_run  (core_run)
    );

    boot_read_guard #(.ADDR_W(ADDR_W), .LOAD_WORDS(LOAD_WORDS)) u_guard (
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .core_run   (core_run),
        .ram_rd_en  (ram_rd_en),
        .rd_blocked (rd_blocked)
    );

endmodule

// File: rtl/boot_loader_chk.sv
module boot_loader_chk #(
    parameter int ADDR_W     = 16,
    parameter int LOAD_WORDS = 256
) (
    input logic              clk,
    input logic              rst,
    input logic              par_ready,
    input logic              ser_ready,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_waddr,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              ram_rd_en,
    input logic              boot_done,
    input logic              core_run
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(LOAD_WORDS);

    logic [ADDR_W-1:0] writes_seen;

    always_ff @(posedge clk) begin
        if (rst) writes_seen <= '0;
        else if (ram_we) writes_seen <= writes_seen + 1'b1;
    end

    // R1
    ready_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({par_ready, ser_ready}));

    // R4
    ready_low_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (!par_ready && !ser_ready));

    // R3
    write_addr_order_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (ram_waddr == writes_seen));

    // R3
    write_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |=> !ram_we);

    // R5
    read_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_rd_en && !core_run) |-> ({1'b0, rd_addr} >= LIMIT));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        boot_done |=> !boot_done);

    // R6
    done_with_run_chk: assert property (@(posedge clk) disable iff (rst)
        boot_done |-> core_run);

    // R6
    run_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        core_run |=> core_run);

    // R8
    no_write_after_run_chk: assert property (@(posedge clk) disable iff (rst)
        core_run |-> (!ram_we && !par_ready && !ser_ready));

endmodule

bind boot_loader_top boot_loader_chk #(.ADDR_W(ADDR_W), .LOAD_WORDS(LOAD_WORDS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .par_ready (par_ready),
    .ser_ready (ser_ready),
    .ram_we    (ram_we),
    .ram_waddr (ram_waddr),
    .rd_addr   (rd_addr),
    .ram_rd_en (ram_rd_en),
    .boot_done (boot_done),
    .core_run  (core_run)
);

// File: tb/tb_boot_loader_top.sv
module tb_boot_loader_top;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 24;
    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 16;
    localparam int LOAD_WORDS = 256;
    localparam int NBYTES     = LOAD_WORDS * 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [2:0]        mode_bits = 3'b000;
    logic              par_valid = 1'b0;
    logic [BYTE_W-1:0] par_data = '0;
    logic              par_ready;
    logic              ser_valid = 1'b0;
    logic [BYTE_W-1:0] ser_data = '0;
    logic              ser_ready;
    logic              ser_fmt_i2c;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr;
    logic [WORD_W-1:0] ram_wdata;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              ram_rd_en;
    logic              rd_blocked;
    logic              boot_done;
    logic              core_run;

    int total = 0;
    int bad   = 0;
    bit ended = 0;
    logic [7:0] prog [0:NBYTES-1];

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_loader_top #(
        .WORD_W(WORD_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .LOAD_WORDS(LOAD_WORDS)
    ) dut (
        .clk(clk), .rst(rst), .mode_bits(mode_bits),
        .par_valid(par_valid), .par_data(par_data), .par_ready(par_ready),
        .ser_valid(ser_valid), .ser_data(ser_data), .ser_ready(ser_ready),
        .ser_fmt_i2c(ser_fmt_i2c),
        .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
        .rd_en(rd_en), .rd_addr(rd_addr), .ram_rd_en(ram_rd_en), .rd_blocked(rd_blocked),
        .boot_done(boot_done), .core_run(core_run)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [WORD_W-1:0] exp_word(input int i);
        return {prog[3*i+2], prog[3*i+1], prog[3*i]};
    endfunction

    function automatic bit exp_rd(input bit en, input int addr, input bit run);
        return en && (addr >= LOAD_WORDS || run);
    endfunction

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Random read probe, checked against the R5 rule
    task automatic probe_read();
        int a;
        rd_en   = ($urandom % 2) == 1;
        a       = int'($urandom % 512);
        rd_addr = ADDR_W'(a);
        #1;
        chk(ram_rd_en == exp_rd(rd_en, a, core_run), "R5 ram_rd_en", 32'(ram_rd_en),
            32'(exp_rd(rd_en, a, core_run)));
        chk(rd_blocked == (rd_en && !exp_rd(rd_en, a, core_run)), "R5 rd_blocked",
            32'(rd_blocked), 32'(rd_en && !exp_rd(rd_en, a, core_run)));
    endtask

    task automatic do_reset(input logic [2:0] m);
        @(negedge clk);
        rst = 1'b1;
        mode_bits = m;
        par_valid = 1'b0;
        ser_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(!ram_we && !boot_done && !core_run && !par_ready && !ser_ready, "R9 reset outputs",
            {27'd0, ram_we, boot_done, core_run, par_ready, ser_ready}, 32'd0);
        rst = 1'b0;
    endtask

    // Load stop_after words (LOAD_WORDS for a full load) from the port chosen by m
    task automatic do_load(input logic [2:0] m, input int stop_after);
        bit use_ser;
        int idx;
        int w;
        int phase;
        bit fin;
        bit v;
        use_ser = (m != 3'b001);
        for (int i = 0; i < NBYTES; i++) prog[i] = 8'($urandom);
        do_reset(m);
        idx = 0; w = 0; phase = 0; fin = 0;
        @(negedge clk);
        // R1 framing output
        chk(ser_fmt_i2c == (m == 3'b011), "R1 ser_fmt_i2c", 32'(ser_fmt_i2c), 32'(m == 3'b011));
        for (int cyc = 0; cyc < 20000 && !fin; cyc++) begin
            if (cyc != 0) @(negedge clk);
            if (phase == 2) begin
                chk(!boot_done && core_run, "R6 done falls, run stays",
                    {30'd0, boot_done, core_run}, 32'd1);
                fin = 1;
            end else if (phase == 1) begin
                chk(boot_done && core_run, "R6 done pulse with run",
                    {30'd0, boot_done, core_run}, 32'd3);
                phase = 2;
            end else if (ram_we) begin
                chk(ram_waddr == ADDR_W'(w), "R3 write address", 32'(ram_waddr), 32'(w));
                chk(ram_wdata == exp_word(w), "R2 packed word", 32'(ram_wdata), 32'(exp_word(w)));
                chk(!par_ready && !ser_ready, "R4 ready low on write",
                    {30'd0, par_ready, ser_ready}, 32'd0);
                chk(!core_run && !boot_done, "R6 held during load",
                    {30'd0, core_run, boot_done}, 32'd0);
                w++;
                if (w == stop_after && stop_after < LOAD_WORDS) fin = 1;
                else if (w == LOAD_WORDS) phase = 1;
            end else begin
                chk(!boot_done && !core_run, "R6 no early release",
                    {30'd0, boot_done, core_run}, 32'd0);
            end
            // R1 unselected port never ready
            if (use_ser) chk(!par_ready, "R1 parallel unselected", 32'(par_ready), 32'd0);
            else         chk(!ser_ready, "R1 serial unselected", 32'(ser_ready), 32'd0);
            // drive next cycle
            v = (($urandom % 4) != 0) && (idx < NBYTES);
            if (use_ser) begin
                ser_valid = v;  ser_data = v ? prog[idx] : 8'hxx;
                par_valid = ($urandom % 2) == 1; par_data = 8'($urandom);
            end else begin
                par_valid = v;  par_data = v ? prog[idx] : 8'hxx;
                ser_valid = ($urandom % 2) == 1; ser_data = 8'($urandom);
            end
            if (v && (use_ser ? ser_ready : par_ready)) idx++;
            probe_read();
        end
        chk(fin, "R3 load finished", 32'(w), 32'(stop_after));
        par_valid = 1'b0;
        ser_valid = 1'b0;
        rd_en = 1'b0;
    endtask

    // Bytes offered after release or in skip mode must be ignored
    task automatic idle_check(input int n, input string req);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            chk(core_run && !ram_we && !boot_done && !par_ready && !ser_ready, req,
                {27'd0, core_run, ram_we, boot_done, par_ready, ser_ready}, 32'h10);
            par_valid = 1'b1; par_data = 8'($urandom);
            ser_valid = 1'b1; ser_data = 8'($urandom);
            probe_read();
        end
        par_valid = 1'b0;
        ser_valid = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h0B00_7123));
        // R1 R2 R3 R4 R5 R6: parallel source, full load
        do_load(3'b001, LOAD_WORDS);
        // R8 ignore after release
        idle_check(12, "R8 ignored after release");
        // R10: abort mid-load, then restart on serial SPI from address 0
        do_load(3'b011, 40);
        do_load(3'b010, LOAD_WORDS);
        // serial I2C framing
        do_load(3'b011, LOAD_WORDS);
        // R7 unsupported codes
        do_reset(3'b000);
        @(negedge clk);
        chk(core_run, "R7 immediate release code 000", 32'(core_run), 32'd1);
        idle_check(8, "R7 no writes code 000");
        do_reset(3'b111);
        @(negedge clk);
        chk(core_run, "R7 immediate release code 111", 32'(core_run), 32'd1);
        idle_check(8, "R7 no writes code 111");
        finish_up();
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

endmodule